// File: doc/BRIEF.md
# Touch Sample Buffer with Status and Interrupt

This block sits between a touch-panel conversion engine and a host. Each time the engine finishes a measurement it presents a pen state and two 10-bit coordinates for one cycle. The block packs them into a 32-bit word and appends the word to a 16-entry first-in first-out store. The host works through a small register interface with one read strobe, one write strobe and a 2-bit word address. It can read a status word, read and write a control word, and pop the oldest sample by reading the data address.

An interrupt level tells the host that enough samples have built up. The number needed is set by one control bit: a single sample, or four of them. The interrupt also stays high while the overrun flag is set. The overrun flag is sticky. It records that a sample arrived while the store was full and was thrown away. It clears when reads drain the store to empty, or on a flush pulse, which empties the store in one cycle.

Top module: `touch_fifo`

## Requirements
- R1: After reset the store is empty, the overrun flag is clear, the control word is zero, `irq` is low and `reg_rdata` is zero.
- R2: A sample is stored as one 32-bit word: bit 31 is `smp_pen_up` (0 means pen down, 1 means pen lifted), bits 25:16 are `smp_x`, bits 9:0 are `smp_y`, and all other bits are zero.
- R3: Word address 2 is the data address. A read there loads the oldest stored word into `reg_rdata` on the next clock edge and removes that word. Samples come out in arrival order.
- R4: Word address 0 is the status address. A read there returns bit 7 = store empty, bit 8 = overrun, bits 20:16 = number of stored words, and zero in every other bit. Word address 3 reads as zero.
- R5: A sample that arrives while 16 words are stored, with no data read in the same cycle, is dropped. It sets the overrun flag and leaves the stored words unchanged.
- R6: Once set, the overrun flag stays set until a data read removes the last stored word with no sample arriving in that cycle, or until a flush.
- R7: A data read while the store is empty returns zero and moves no pointer, so later samples come out correctly.
- R8: `irq` is high exactly when the overrun flag is set or the word count is at least the threshold. The threshold is 4 when control bit 11 is 1, and 1 when that bit is 0.
- R9: Word address 1 is the control address. A write there stores all 32 bits of `reg_wdata`, and a read there returns them. Only bit 11 has an effect. Writes to any other address have no effect.
- R10: A flush pulse empties the store and clears the overrun flag in one cycle. A sample arriving in the flush cycle is dropped, and a data read in that cycle returns zero.
- R11: A sample and a data read in the same cycle are both carried out. When the store is full this sets no overrun and keeps the count at 16. When the store is empty the read returns zero and the sample is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample is present this cycle |
| smp_pen_up | input | 1 | Pen state of the sample, 1 = lifted |
| smp_x | input | 10 | X coordinate of the sample |
| smp_y | input | 10 | Y coordinate of the sample |
| flush | input | 1 | Empty the store and clear the overrun flag |
| reg_rd | input | 1 | Host read strobe |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 control, 2 data, 3 unused |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt level |

## Verification
The properties assume that both strobes and `flush` are sampled only at the rising edge, and that `reg_addr` is stable while `reg_rd` is high. They also assume that the word count seen through the checker follows only pushes, pops and flushes. The stimulus changes every input at the falling edge and returns each one to idle after a single cycle. It issues combined push-with-read and flush cycles on purpose, so that the full-store and empty-store corner cases in the overrun and empty-read properties are reached from a well-defined state.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    localparam int WORD_W    = 32;
    localparam int PEN_BIT   = 31;
    localparam int X_LSB     = 16;
    localparam int Y_LSB     = 0;
    localparam int EMPTY_BIT = 7;
    localparam int OVR_BIT   = 8;
    localparam int CNT_LSB   = 16;
    localparam int THR4_BIT  = 11;

    typedef enum logic [1:0] {
        ADR_STATUS = 2'd0,
        ADR_CTRL   = 2'd1,
        ADR_DATA   = 2'd2,
        ADR_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int W     = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    // One register per entry; each loads only when addressed.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) begin
                cell_q <= wdata;
            end
        end
        assign cells[i] = cell_q;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/tsf_ctl.sv
module tsf_ctl #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop_req,
    input  logic          flush,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          ovr
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_C  = CW'(1);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } ctl_t;

    ctl_t st_q, st_d;
    logic can_pop, do_push;

    always_comb begin
        st_d    = st_q;
        can_pop = 1'b0;
        do_push = 1'b0;
        if (flush) begin
            st_d = '0;
        end else begin
            can_pop = pop_req && (st_q.cnt != '0);
            // A pop in the same cycle frees the slot the push needs.
            do_push = push && ((st_q.cnt != FULL_C) || can_pop);
            if (push && !do_push) begin
                st_d.ovr = 1'b1;
            end
            if (do_push) begin
                st_d.wp = (st_q.wp == LAST_C) ? '0 : st_q.wp + 1'b1;
            end
            if (can_pop) begin
                st_d.rp = (st_q.rp == LAST_C) ? '0 : st_q.rp + 1'b1;
            end
            case ({do_push, can_pop})
                2'b10:   st_d.cnt = st_q.cnt + ONE_C;
                2'b01:   st_d.cnt = st_q.cnt - ONE_C;
                default: st_d.cnt = st_q.cnt;
            endcase
            // Draining the last word by a read releases the overrun flag.
            if (can_pop && !do_push && (st_q.cnt == ONE_C)) begin
                st_d.ovr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en  = do_push;
    assign wr_ptr = st_q.wp;
    assign rd_ptr = st_q.rp;
    assign count  = st_q.cnt;
    assign ovr    = st_q.ovr;
endmodule

// File: rtl/tsf_regs.sv
module tsf_regs
    import tsf_pkg::*;
#(
    parameter int CW     = 5,
    parameter int THR_HI = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              flush,
    input  logic [CW-1:0]     count,
    input  logic              ovr,
    input  logic [WORD_W-1:0] head,
    output logic              pop_req,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);
    localparam logic [CW-1:0] THR_HI_C = CW'(THR_HI);
    localparam logic [CW-1:0] THR_LO_C = CW'(1);

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    regs_t rg_q, rg_d;
    logic [WORD_W-1:0] stat_w;
    logic              empty;
    logic [CW-1:0]     thr;
    reg_addr_e         adr;

    assign adr   = reg_addr_e'(reg_addr);
    assign empty = (count == '0);

    always_comb begin
        stat_w                   = '0;
        stat_w[EMPTY_BIT]        = empty;
        stat_w[OVR_BIT]          = ovr;
        stat_w[CNT_LSB +: CW]    = count;
    end

    always_comb begin
        rg_d = rg_q;
        if (reg_wr && (adr == ADR_CTRL)) begin
            rg_d.ctrl = reg_wdata;
        end
        if (reg_rd) begin
            case (adr)
                ADR_STATUS: rg_d.rdata = stat_w;
                ADR_CTRL:   rg_d.rdata = rg_q.ctrl;
                ADR_DATA:   rg_d.rdata = (flush || empty) ? '0 : head;
                default:    rg_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign pop_req   = reg_rd && (adr == ADR_DATA);
    assign thr       = rg_q.ctrl[THR4_BIT] ? THR_HI_C : THR_LO_C;
    assign irq       = ovr || (count >= thr);
    assign reg_rdata = rg_q.rdata;
endmodule

// File: rtl/touch_fifo.sv
module touch_fifo
    import tsf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int COORD_W = 10,
    parameter int THR_HI  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic               smp_pen_up,
    input  logic [COORD_W-1:0] smp_x,
    input  logic [COORD_W-1:0] smp_y,
    input  logic               flush,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] push_word;
    logic [WORD_W-1:0] head_word;
    logic              wr_en;
    logic              pop_req;
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     fill_cnt;
    logic              ovr_flag;

    always_comb begin
        push_word                      = '0;
        push_word[PEN_BIT]             = smp_pen_up;
        push_word[X_LSB +: COORD_W]    = smp_x;
        push_word[Y_LSB +: COORD_W]    = smp_y;
    end

    tsf_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (smp_valid),
        .pop_req (pop_req),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (fill_cnt),
        .ovr     (ovr_flag)
    );

    tsf_store #(.DEPTH(DEPTH), .AW(AW), .W(WORD_W)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (push_word),
        .raddr (rd_ptr),
        .rdata (head_word)
    );

    tsf_regs #(.CW(CW), .THR_HI(THR_HI)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flush     (flush),
        .count     (fill_cnt),
        .ovr       (ovr_flag),
        .head      (head_word),
        .pop_req   (pop_req),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );
endmodule

// File: rtl/touch_fifo_chk.sv
module touch_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic          flush,
    input logic          irq,
    input logic [31:0]   reg_rdata,
    input logic [CW-1:0] count,
    input logic          ovr
);
    logic pop_rd;
    assign pop_rd = reg_rd && (reg_addr == 2'd2);

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) && smp_valid && !pop_rd && !flush
        |=> ovr && (count == CW'(DEPTH)));

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !flush && (count > CW'(1)) |=> ovr);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (count == $past(count)) || (count == $past(count) + CW'(1))
                   || ($past(count) == count + CW'(1)));

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_rd && (count == '0) |=> reg_rdata == 32'd0);

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && !ovr);

    // R8
    irq_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> irq);
endmodule

bind touch_fifo touch_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .flush     (flush),
    .irq       (irq),
    .reg_rdata (reg_rdata),
    .count     (fill_cnt),
    .ovr       (ovr_flag)
);

// File: tb/touch_fifo_tb.sv
`timescale 1ns/1ps
module touch_fifo_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_pen_up = 1'b0;
    logic [9:0]  smp_x = '0;
    logic [9:0]  smp_y = '0;
    logic        flush = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    touch_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_pen_up(smp_pen_up),
        .smp_x(smp_x), .smp_y(smp_y), .flush(flush), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] pk(input logic pen, input logic [9:0] x, input logic [9:0] y);
        return {pen, 5'b0, x, 6'b0, y};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0] mq[$];
    logic        movr;
    logic [31:0] mctrl;
    logic [31:0] mrd;
    logic [31:0] mstat;
    int          msz;
    logic        mpop;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); movr = 1'b0; mctrl = '0; mrd = '0;
        end else begin
            msz = mq.size();
            mstat = '0;
            mstat[7] = (msz == 0);
            mstat[8] = movr;
            mstat[20:16] = msz[4:0];
            if (reg_rd) begin
                case (reg_addr)
                    2'd0: mrd = mstat;
                    2'd1: mrd = mctrl;
                    2'd2: mrd = (flush || msz == 0) ? 32'd0 : mq[0];
                    default: mrd = 32'd0;
                endcase
            end
            if (reg_wr && reg_addr == 2'd1) mctrl = reg_wdata;
            if (flush) begin
                mq.delete(); movr = 1'b0;
            end else begin
                mpop = reg_rd && reg_addr == 2'd2 && msz > 0;
                if (mpop) void'(mq.pop_front());
                if (smp_valid) begin
                    if (msz == DEPTH && !mpop) movr = 1'b1;
                    else mq.push_back(pk(smp_pen_up, smp_x, smp_y));
                end
                if (mpop && !smp_valid && msz == 1) movr = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 model rdata", reg_rdata, mrd);
            check("R8 model irq", {31'b0, irq},
                  {31'b0, movr || (mq.size() >= (mctrl[11] ? 4 : 1))});
        end
    end

    task automatic step(input logic v, input logic pen, input logic [9:0] x, input logic [9:0] y,
                        input logic rd, input logic [1:0] a, input logic wr,
                        input logic [31:0] wd, input logic fl);
        smp_valid = v; smp_pen_up = pen; smp_x = x; smp_y = y;
        reg_rd = rd; reg_addr = a; reg_wr = wr; reg_wdata = wd; flush = fl;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; flush = 1'b0;
    endtask

    task automatic push(input logic pen, input logic [9:0] x, input logic [9:0] y);
        step(1'b1, pen, x, y, 1'b0, 2'd0, 1'b0, 32'd0, 1'b0);
    endtask

    task automatic rd(input logic [1:0] a);
        step(1'b0, 1'b0, 10'd0, 10'd0, 1'b1, a, 1'b0, 32'd0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rdata at reset", reg_rdata, 32'd0);
        check("R1 irq at reset", {31'b0, irq}, 32'd0);
        rst_n = 1'b1;
        rd(2'd0); check("R1 status after reset", reg_rdata, 32'h0000_0080);
        rd(2'd1); check("R1 control after reset", reg_rdata, 32'd0);
        rd(2'd3); check("R4 unused address", reg_rdata, 32'd0);

        // Single sample, threshold 1
        push(1'b0, 10'h155, 10'h2AA);
        check("R8 irq at one word thr1", {31'b0, irq}, 32'd1);
        rd(2'd0); check("R4 status one word", reg_rdata, 32'h0001_0000);
        rd(2'd2); check("R2 packing pen down", reg_rdata, 32'h0155_02AA);
        check("R8 irq low when empty", {31'b0, irq}, 32'd0);
        push(1'b1, 10'h3FF, 10'h001);
        rd(2'd2); check("R2 packing pen up", reg_rdata, 32'h83FF_0001);

        // Control register, threshold 4
        step(1'b0, 1'b0, 10'd0, 10'd0, 1'b0, 2'd1, 1'b1, 32'hA5A5_0800, 1'b0);
        step(1'b0, 1'b0, 10'd0, 10'd0, 1'b0, 2'd0, 1'b1, 32'hFFFF_FFFF, 1'b0);
        step(1'b0, 1'b0, 10'd0, 10'd0, 1'b0, 2'd2, 1'b1, 32'hFFFF_FFFF, 1'b0);
        rd(2'd1); check("R9 control readback", reg_rdata, 32'hA5A5_0800);
        rd(2'd0); check("R9 write to status ignored", reg_rdata, 32'h0000_0080);
        for (int i = 0; i < 3; i++) push(1'b0, 10'(i + 1), 10'(i + 100));
        check("R8 irq low at three words thr4", {31'b0, irq}, 32'd0);
        push(1'b0, 10'd4, 10'd103);
        check("R8 irq high at four words thr4", {31'b0, irq}, 32'd1);
        for (int i = 0; i < 4; i++) begin
            rd(2'd2); check("R3 order", reg_rdata, pk(1'b0, 10'(i + 1), 10'(i + 100)));
        end

        // Empty read
        rd(2'd2); check("R7 empty read zero", reg_rdata, 32'd0);
        push(1'b0, 10'd77, 10'd88);
        rd(2'd2); check("R7 pointers kept", reg_rdata, pk(1'b0, 10'd77, 10'd88));

        // Overrun
        for (int i = 0; i < DEPTH; i++) push(1'b0, 10'(i), 10'(DEPTH - i));
        push(1'b1, 10'h3FF, 10'h3FF);
        rd(2'd0); check("R5 overrun status", reg_rdata, 32'h0010_0100);
        check("R8 irq with overrun", {31'b0, irq}, 32'd1);
        for (int i = 0; i < DEPTH - 1; i++) begin
            rd(2'd2); check("R5 contents kept", reg_rdata, pk(1'b0, 10'(i), 10'(DEPTH - i)));
        end
        rd(2'd0); check("R6 overrun sticky", reg_rdata, 32'h0001_0100);
        rd(2'd2); check("R5 last word not dropped sample", reg_rdata, pk(1'b0, 10'(DEPTH - 1), 10'd1));
        rd(2'd0); check("R6 overrun cleared on drain", reg_rdata, 32'h0000_0080);

        // Full with push and pop together, then flush
        for (int i = 0; i < DEPTH; i++) push(1'b0, 10'(i + 200), 10'd5);
        step(1'b1, 1'b0, 10'd999, 10'd9, 1'b1, 2'd2, 1'b0, 32'd0, 1'b0);
        check("R11 pop at full", reg_rdata, pk(1'b0, 10'd200, 10'd5));
        rd(2'd0); check("R11 no overrun count 16", reg_rdata, 32'h0010_0000);
        push(1'b0, 10'd1, 10'd1);
        rd(2'd0); check("R5 overrun before flush", reg_rdata, 32'h0010_0100);
        step(1'b1, 1'b0, 10'd3, 10'd3, 1'b1, 2'd2, 1'b0, 32'd0, 1'b1);
        check("R10 read in flush cycle", reg_rdata, 32'd0);
        rd(2'd0); check("R10 flush clears", reg_rdata, 32'h0000_0080);
        check("R10 irq low after flush", {31'b0, irq}, 32'd0);

        // Empty store with push and pop together
        step(1'b1, 1'b0, 10'd21, 10'd22, 1'b1, 2'd2, 1'b0, 32'd0, 1'b0);
        check("R11 empty push pop read zero", reg_rdata, 32'd0);
        rd(2'd0); check("R11 sample stored", reg_rdata, 32'h0001_0000);
        rd(2'd2); check("R11 stored word", reg_rdata, pk(1'b0, 10'd21, 10'd22));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule